// File: doc/BRIEF.md
# Misaligned Access Bus-Cycle Splitter

This block sits between a load/store unit and a 32-bit big-endian data bus. It takes one memory request, made of a byte address, an access size (byte, halfword or word), a load/store flag and right-justified store data. It issues the request as a short series of naturally aligned bus cycles, never a cycle that crosses its own natural boundary. Each cycle is presented on a request/acknowledge handshake with its own address, size and byte-lane data. The next cycle waits for the acknowledge of the current one.

On a store, the block slices the store data so that each byte travels on the lane its address selects. On a load, it collects the bytes returned by each cycle and builds the full value, with the byte at the lowest address as the most significant. When the last cycle is acknowledged, the block raises a one-clock completion pulse. It also shows the loaded value and how many bus cycles the request took. A misaligned halfword costs two cycles. A misaligned word costs two or three cycles of mixed byte and halfword width.

Top module: `bus_split_unit`

## Requirements
- R1: A byte request (size code 0) at any address is issued as exactly one byte cycle at that address.
- R2: A halfword (size code 1) at an address with low bits 0 or 2, or a word (size code 2) at low bits 0, is issued as one cycle of that same size at that address.
- R3: A halfword at low bits 1 or 3 is issued as two byte cycles, at the request address and then at the next address.
- R4: A word at low bits 2 is issued as two halfword cycles, at the request address A and then at A+2.
- R5: A word at low bits 1 or 3 is issued as three cycles: a byte at A, a halfword at A+1 and a byte at A+3.
- R6: Cycles go out in ascending address order, and each is naturally aligned. Once raised, the bus request and its address and size stay unchanged until the acknowledge. The next cycle starts only after that acknowledge.
- R7: A load result is right-justified on the result output, with the lowest-addressed byte as the most significant. The bus byte lane for address a is bits [31-8*(a mod 4) -: 8].
- R8: On a store, every byte of a cycle is driven on the bus lane its address selects (same lane mapping as R7). Its value is byte j of the request data, where j is the distance from the request address and byte 0 is the most significant byte of the access size.
- R9: Completion is high for exactly one clock, the clock after the last acknowledge. Then the cycle count output equals the number of bus cycles used. The result and the count hold until the next request is accepted.
- R10: A request is accepted only while the ready output is high, and ready is high only when idle. A request offered while busy has no effect on the bus cycles in progress, and it starts no later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_addr_i | input | AW | Request byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_store_i | input | 1 | 1 store, 0 load |
| req_wdata_i | input | 32 | Store data, right-justified |
| bus_req_o | output | 1 | Bus cycle request |
| bus_ack_i | input | 1 | Bus cycle acknowledge |
| bus_addr_o | output | AW | Bus cycle byte address |
| bus_size_o | output | 2 | Bus cycle size, same coding as request |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_wdata_o | output | 32 | Write data on byte lanes |
| bus_rdata_i | input | 32 | Read data on byte lanes, valid with acknowledge |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Assembled load result |
| ncycles_o | output | 2 | Bus cycles used by the last request |

## Verification
The assertions assume that the size code is never 3, and that the acknowledge is only meaningful while the bus request is high. They also assume the read data is valid in the acknowledge cycle. The bench drives only sizes 0 to 2 and raises acknowledge only while it sees a request. It holds the acknowledge for one clock per cycle, placing the read word for the addressed aligned word on all four lanes. The bench varies the wait before each acknowledge so that the hold-until-acknowledge rule is exercised. It also offers a stray request mid-transfer to show that this request is ignored.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int unsigned BUS_BYTES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/bsu_plan.sv
// Picks the largest naturally aligned piece at the current lane.
module bsu_plan
  import bsu_pkg::*;
(
  input  logic [1:0] lane_i,
  input  logic [2:0] rem_i,
  output size_e      piece_o,
  output logic [2:0] nbytes_o
);
  always_comb begin
    if (lane_i == 2'd0 && rem_i >= 3'd4) begin
      piece_o  = SZ_WORD;
      nbytes_o = 3'd4;
    end else if (!lane_i[0] && rem_i >= 3'd2) begin
      piece_o  = SZ_HALF;
      nbytes_o = 3'd2;
    end else begin
      piece_o  = SZ_BYTE;
      nbytes_o = 3'd1;
    end
  end
endmodule

// File: rtl/bsu_lanes.sv
// Maps piece bytes to and from big-endian bus lanes.
module bsu_lanes #(
  parameter int unsigned BB = 4,
  localparam int unsigned DW = 8 * BB
) (
  input  logic [1:0]    lane_i,
  input  logic [2:0]    nbytes_i,
  input  logic [DW-1:0] wsh_i,    // pending store bytes, left-justified
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] piece_o   // read piece, right-justified
);
  logic [DW-1:0] mask;
  int unsigned   pad;

  always_comb begin
    pad     = BB - int'(nbytes_i);
    mask    = {DW{1'b1}} << (8 * pad);
    wdata_o = (wsh_i & mask) >> (8 * int'(lane_i));
    piece_o = (rdata_i << (8 * int'(lane_i))) >> (8 * pad);
  end
endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit
  import bsu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_store_i,
  input  logic [31:0]   req_wdata_i,
  output logic          bus_req_o,
  input  logic          bus_ack_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic          bus_we_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i,
  output logic          done_o,
  output logic [31:0]   rdata_o,
  output logic [1:0]    ncycles_o
);
  localparam int unsigned DW = 8 * BUS_BYTES;

  logic          busy_q, we_q, done_q;
  logic [AW-1:0] cur_q;
  logic [2:0]    rem_q;
  logic [DW-1:0] wsh_q, acc_q;
  logic [1:0]    cnt_q;

  size_e         piece;
  logic [2:0]    nbytes, req_nb;
  logic [DW-1:0] lane_wdata, rd_piece;
  logic          accept, step, last;

  bsu_plan u_plan (
    .lane_i   (cur_q[1:0]),
    .rem_i    (rem_q),
    .piece_o  (piece),
    .nbytes_o (nbytes)
  );

  bsu_lanes #(.BB(BUS_BYTES)) u_lanes (
    .lane_i   (cur_q[1:0]),
    .nbytes_i (nbytes),
    .wsh_i    (wsh_q),
    .rdata_i  (bus_rdata_i),
    .wdata_o  (lane_wdata),
    .piece_o  (rd_piece)
  );

  assign req_nb = size_bytes(req_size_i);
  assign accept = req_valid_i && !busy_q;
  assign step   = busy_q && bus_ack_i;
  assign last   = step && (rem_q == nbytes);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      cur_q  <= '0;
      rem_q  <= '0;
      wsh_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        cur_q  <= req_addr_i;
        rem_q  <= req_nb;
        we_q   <= req_store_i;
        wsh_q  <= req_wdata_i << (8 * (BUS_BYTES - int'(req_nb)));
        acc_q  <= '0;
        cnt_q  <= '0;
      end else if (step) begin
        cur_q <= cur_q + {{(AW-3){1'b0}}, nbytes};
        rem_q <= rem_q - nbytes;
        wsh_q <= wsh_q << (8 * int'(nbytes));
        cnt_q <= cnt_q + 2'd1;
        if (!we_q) acc_q <= (acc_q << (8 * int'(nbytes))) | rd_piece;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign bus_req_o   = busy_q;
  assign bus_addr_o  = cur_q;
  assign bus_size_o  = piece;
  assign bus_we_o    = we_q;
  assign bus_wdata_o = lane_wdata;
  assign done_o      = done_q;
  assign rdata_o     = acc_q;
  assign ncycles_o   = cnt_q;

  p_hold_until_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_size_o));

  p_aligned_piece_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_size_o != 2'd3) &&
                  (bus_size_o != 2'd1 || !bus_addr_o[0]) &&
                  (bus_size_o != 2'd2 || bus_addr_o[1:0] == 2'd0));

  p_ascending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && $past(bus_req_o && bus_ack_i) |->
      bus_addr_o == $past(bus_addr_o) + {{(AW-3){1'b0}}, size_bytes($past(bus_size_o))});

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_req_o && bus_ack_i) && !bus_req_o);

  p_count_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ncycles_o != 2'd0);

  p_idle_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
endmodule

// File: tb/bus_split_unit_bench.sv
module bus_split_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_store_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        bus_req_o;
  logic        bus_ack_i = 1'b0;
  logic [31:0] bus_addr_o;
  logic [1:0]  bus_size_o;
  logic        bus_we_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic        done_o;
  logic [31:0] rdata_o;
  logic [1:0]  ncycles_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_split_unit #(.AW(32)) u_bus_split_unit (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [31:0] a);
    return 8'(a * 37 + 5);
  endfunction

  function automatic string tag(input int sz, input int off);
    if (sz == 0) return "R1";
    if (sz == 1) return (off % 2 == 0) ? "R2" : "R3";
    if (off == 0) return "R2";
    if (off == 2) return "R4";
    return "R5";
  endfunction

  task automatic run(input int sz, input int off, input bit st,
                     input logic [31:0] base, input logic [31:0] data, input bit poke);
    int nb, n;
    int rel[3];
    int psz[3];
    logic [31:0] a0, exp_r;
    string t;
    nb = 1 << sz;
    a0 = base + 32'(off);
    t  = tag(sz, off);
    n  = 1;
    rel[0] = 0; psz[0] = sz;
    if (sz == 1 && off % 2 == 1) begin
      n = 2; psz[0] = 0; rel[1] = 1; psz[1] = 0;
    end else if (sz == 2 && off == 2) begin
      n = 2; psz[0] = 1; rel[1] = 2; psz[1] = 1;
    end else if (sz == 2 && off % 2 == 1) begin
      n = 3; psz[0] = 0; rel[1] = 1; psz[1] = 1; rel[2] = 3; psz[2] = 0;
    end
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10 ready when idle", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; req_addr_i = a0; req_size_i = 2'(sz);
    req_store_i = st; req_wdata_i = data;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] pa, exp_w, mask;
      int waits;
      pa = a0 + 32'(rel[i]);
      waits = (i + off) % 3 + ((poke && i == 0) ? 1 : 0);
      for (int d = 0; d < waits; d++) begin
        chk(bus_req_o && bus_addr_o == pa, "R6 request held", bus_addr_o, pa);
        chk(req_ready_o == 1'b0, "R10 not ready while busy", 32'(req_ready_o), 32'd0);
        if (poke && i == 0 && d == 0) begin
          req_valid_i = 1'b1; req_addr_i = 32'h0000_0F00; req_size_i = 2'd2;
          req_store_i = ~st; req_wdata_i = 32'hDEAD_BEEF;
        end
        @(negedge clk_i);
        req_valid_i = 1'b0;
      end
      chk(bus_req_o == 1'b1, {t, " request raised"}, 32'(bus_req_o), 32'd1);
      chk(bus_addr_o == pa, {t, " piece address"}, bus_addr_o, pa);
      chk(bus_size_o == 2'(psz[i]), {t, " piece size"}, 32'(bus_size_o), 32'(psz[i]));
      chk(bus_we_o == st, "R8 write flag", 32'(bus_we_o), 32'(st));
      if (st) begin
        exp_w = '0; mask = '0;
        for (int k = 0; k < (1 << psz[i]); k++) begin
          int ln, j;
          ln = int'((pa + 32'(k)) % 4);
          j  = rel[i] + k;
          exp_w[8*(3-ln) +: 8] = data[8*(nb-1-j) +: 8];
          mask[8*(3-ln) +: 8]  = 8'hFF;
        end
        chk((bus_wdata_o & mask) == exp_w, "R8 store lanes", bus_wdata_o & mask, exp_w);
      end
      bus_ack_i = 1'b1;
      for (int ln = 0; ln < 4; ln++)
        bus_rdata_i[8*(3-ln) +: 8] = mem({pa[31:2], 2'b00} + 32'(ln));
      @(negedge clk_i);
      bus_ack_i = 1'b0;
      bus_rdata_i = '0;
    end
    chk(done_o == 1'b1, "R9 done after last ack", 32'(done_o), 32'd1);
    chk(ncycles_o == 2'(n), {"R9 cycle count ", t}, 32'(ncycles_o), 32'(n));
    chk(bus_req_o == 1'b0, "R6 no request after last", 32'(bus_req_o), 32'd0);
    if (!st) begin
      exp_r = '0;
      for (int j = 0; j < nb; j++) exp_r = (exp_r << 8) | 32'(mem(a0 + 32'(j)));
      chk(rdata_o == exp_r, "R7 load assembly", rdata_o, exp_r);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done one clock", 32'(done_o), 32'd0);
    chk(bus_req_o == 1'b0, "R10 stray request started nothing", 32'(bus_req_o), 32'd0);
    chk(ncycles_o == 2'(n), "R9 count holds", 32'(ncycles_o), 32'(n));
  endtask

  initial begin
    logic [31:0] bases[3];
    bases[0] = 32'h0000_1000;
    bases[1] = 32'h0000_2FFC;
    bases[2] = 32'h0000_7F30;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10 reset ready", 32'(req_ready_o), 32'd1);
    chk(bus_req_o == 1'b0, "R6 reset no request", 32'(bus_req_o), 32'd0);
    chk(done_o == 1'b0, "R9 reset done low", 32'(done_o), 32'd0);
    chk(ncycles_o == 2'd0, "R9 reset count", 32'(ncycles_o), 32'd0);
    rst_ni = 1'b1;
    for (int b = 0; b < 3; b++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 3; sz++)
          for (int off = 0; off < 4; off++)
            run(sz, off, st[0], bases[b],
                32'h1357_9BDF ^ (bases[b] << 3) ^ 32'(sz * 16 + off * 4 + st), 1'b0);
    for (int off = 0; off < 4; off++) begin
      run(2, off, 1'b0, 32'h0000_4400, 32'h0, 1'b1);
      run(2, off, 1'b1, 32'h0000_4400, 32'hA1B2_C3D4, 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule